// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block gives every CPU in a cluster of up to 31 cores two inter-processor interrupts. The "other" kind is raised from any CPU. The "self" kind is raised by a CPU only for itself. Each CPU has a two-bit pending state and a two-bit mask. In both, the "other" kind sits at bit 0 and the "self" kind at bit 31 of every register word.

Software reaches the unit over a simple register bus. Each access carries the index of the accessing CPU as a sideband. A current-CPU window acts on whichever CPU is accessing. A set of explicit per-CPU windows acts on a chosen CPU no matter who accesses it.

A pending IPI that is not masked becomes a typed event word on that CPU's event port and raises its interrupt line. When the downstream arbiter takes the event, the reported kind is masked automatically. It stays masked until software clears the mask.

Top module: `ipi_unit`

## Requirements
- R1: After reset every CPU has no pending IPI and both kinds masked (mask readback 32'h8000_0001). Every event word is zero and every interrupt line is low.
- R2: Reading 0x2000 returns the index carried on the CPU sideband, zero-extended.
- R3: A write to 0x2008 with bit c set, for c below NUM_CPUS, makes the "other" IPI pending on CPU c. Bit 31 makes the "self" IPI pending on the writing CPU. Bits for CPU indices at or above NUM_CPUS change nothing.
- R4: A write to 0x200c clears the current CPU's pending "other" IPI where bit 0 is 1 and its pending "self" IPI where bit 31 is 1. Reading 0x200c returns the pending bits at positions 0 and 31.
- R5: Writing 0x2024 sets, and writing 0x2028 clears, the current CPU's mask bits selected by 1s in bits 0 and 31. Reading 0x2024 returns the mask at bits 0 and 31.
- R6: The windows for CPU c are at 0x5008 (raise pending), 0x500c (clear pending), 0x5024 (set mask) and 0x5028 (clear mask), each plus c<<7. They act on CPU c whatever the sideband index is.
- R7: A CPU with a pending, unmasked IPI presents an event word with type 4 in bits [31:16] and number 1 ("other") or 2 ("self") in bits [15:0], and drives its interrupt line high. Otherwise the word is zero and the line is low.
- R8: When both kinds are live, the "other" event is presented first.
- R9: Pulsing the take input while an event is presented sets the mask bit of the presented kind one cycle later. The pending state is left unchanged.
- R10: An IPI raised while masked stays pending, and it is presented as soon as its mask is cleared.
- R11: If a take and a mask-clear write for the same kind land in the same cycle, the kind ends up masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 5 | Index of the accessing CPU |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_take | input | NUM_CPUS | Per-CPU pulse: arbiter consumes the presented event |
| ev_data | output | 32*NUM_CPUS | Per-CPU event word, CPU c at bits [32c+31:32c] |
| irq_out | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
Two things can land on the same mask bit in one cycle: the arbiter taking an event and software clearing the mask. Both can also coincide with a send or an acknowledge to the same CPU. The bench pulses take in the same cycle as random register writes. It also provokes the clash directly: a live "other" event is taken while a mask-clear for bit 0 of the same CPU is written. A bench model applies the write first and the auto-mask last, then judges the mask readback and the event word.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int unsigned CPU_W = 5;
   localparam int unsigned MAX_CPUS = 31;
   localparam int unsigned STRIDE_SH = 7;

   localparam logic [15:0] A_WHO   = 16'h2000;
   localparam logic [15:0] A_SEND  = 16'h2008;
   localparam logic [15:0] A_ACK   = 16'h200c;
   localparam logic [15:0] A_MSET  = 16'h2024;
   localparam logic [15:0] A_MCLR  = 16'h2028;
   localparam logic [15:0] A_PSET  = 16'h5008;
   localparam logic [15:0] A_PCLR  = 16'h500c;
   localparam logic [15:0] A_PMSET = 16'h5024;
   localparam logic [15:0] A_PMCLR = 16'h5028;

   localparam logic [15:0] EV_TYPE_IPI = 16'd4;
   localparam logic [15:0] EV_NUM_OTHER = 16'd1;
   localparam logic [15:0] EV_NUM_SELF  = 16'd2;

   typedef enum logic {KIND_OTHER = 1'b0, KIND_SELF = 1'b1} ipi_kind_e;

   typedef struct packed {
      logic [1:0] raise;
      logic [1:0] drop;
      logic [1:0] mset;
      logic [1:0] mclr;
   } ipi_cmd_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 4
) (
   input  logic                 wr_i,
   input  logic [15:0]          addr_i,
   input  logic [31:0]          wdata_i,
   input  logic [CPU_W-1:0]     cpu_i,
   output ipi_cmd_t [NUM_CPUS-1:0] cmd_o
);
   logic [1:0] sel2;
   assign sel2 = {wdata_i[31], wdata_i[0]};

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      localparam logic [15:0] OFS = 16'(c << STRIDE_SH);
      logic cur, h_send, h_ack, h_mset, h_mclr, h_pset, h_pclr, h_pmset, h_pmclr;
      assign cur     = (cpu_i == CPU_W'(c));
      assign h_send  = wr_i && addr_i == A_SEND;
      assign h_ack   = wr_i && cur && addr_i == A_ACK;
      assign h_mset  = wr_i && cur && addr_i == A_MSET;
      assign h_mclr  = wr_i && cur && addr_i == A_MCLR;
      assign h_pset  = wr_i && addr_i == A_PSET + OFS;
      assign h_pclr  = wr_i && addr_i == A_PCLR + OFS;
      assign h_pmset = wr_i && addr_i == A_PMSET + OFS;
      assign h_pmclr = wr_i && addr_i == A_PMCLR + OFS;

      always_comb begin
         cmd_o[c].raise[KIND_OTHER] = (h_send && wdata_i[c]) || (h_pset && wdata_i[0]);
         cmd_o[c].raise[KIND_SELF]  = (h_send && cur && wdata_i[31]) || (h_pset && wdata_i[31]);
         cmd_o[c].drop = (h_ack || h_pclr)   ? sel2 : 2'b00;
         cmd_o[c].mset = (h_mset || h_pmset) ? sel2 : 2'b00;
         cmd_o[c].mclr = (h_mclr || h_pmclr) ? sel2 : 2'b00;
      end
   end
endmodule

// File: rtl/ipi_slice.sv
module ipi_slice
   import ipi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  ipi_cmd_t   cmd_i,
   input  logic       take_i,
   output logic [1:0] pend_o,
   output logic [1:0] mask_o,
   output logic       req_o,
   output logic [31:0] data_o
);
   logic [1:0] pend_q, mask_q, live, auto_m;
   ipi_kind_e  pick;

   assign live   = pend_q & ~mask_q;
   assign pick   = live[KIND_OTHER] ? KIND_OTHER : KIND_SELF;
   assign req_o  = |live;
   assign data_o = req_o ? {EV_TYPE_IPI, (pick == KIND_OTHER) ? EV_NUM_OTHER : EV_NUM_SELF} : 32'd0;

   always_comb begin
      auto_m = 2'b00;
      if (take_i && req_o) auto_m[pick] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 2'b00;
         mask_q <= 2'b11;
      end else begin
         pend_q <= (pend_q | cmd_i.raise) & ~cmd_i.drop;
         mask_q <= ((mask_q | cmd_i.mset) & ~cmd_i.mclr) | auto_m;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   AST_RAISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i.raise[0] && !cmd_i.drop[0]) |=> pend_o[0]);                    // R10
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i.drop[1] && !cmd_i.raise[1]) |=> !pend_o[1]);                   // R4
   AST_OTHER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[0] && !mask_o[0]) |-> (data_o[15:0] == 16'd1));               // R8
   AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && data_o == 32'h0004_0002) |=> mask_o[1]);                   // R9
   AST_TAKE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && data_o == 32'h0004_0001 && cmd_i.mclr[0]) |=> mask_o[0]);  // R11
   AST_TAKE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && req_o && cmd_i.drop == 2'b00) |=> $stable(pend_o) || $rose(pend_o[0]) || $rose(pend_o[1])); // R9
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic [15:0]              bus_addr,
   input  logic [31:0]              bus_wdata,
   input  logic [4:0]               bus_cpu,
   output logic [31:0]              bus_rdata,
   input  logic [NUM_CPUS-1:0]      ev_take,
   output logic [NUM_CPUS*32-1:0]   ev_data,
   output logic [NUM_CPUS-1:0]      irq_out
);
   if (NUM_CPUS < 1 || NUM_CPUS > MAX_CPUS) begin : g_bad_cfg
      $error("ipi_unit: NUM_CPUS must lie in 1..31");
   end

   ipi_cmd_t [NUM_CPUS-1:0] cmd;
   logic [NUM_CPUS-1:0][1:0] pend, mask;

   ipi_decode #(.NUM_CPUS(NUM_CPUS)) u_dec (
      .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
      .cpu_i(bus_cpu), .cmd_o(cmd)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_slice
      ipi_slice u_sl (
         .clk(clk), .rst_n(rst_n), .cmd_i(cmd[c]), .take_i(ev_take[c]),
         .pend_o(pend[c]), .mask_o(mask[c]), .req_o(irq_out[c]),
         .data_o(ev_data[c*32 +: 32])
      );
   end

   logic [1:0] cur_pend, cur_mask;
   always_comb begin
      cur_pend = 2'b00;
      cur_mask = 2'b00;
      for (int c = 0; c < NUM_CPUS; c++) begin
         if (bus_cpu == CPU_W'(c)) begin
            cur_pend = pend[c];
            cur_mask = mask[c];
         end
      end
   end

   always_comb begin
      unique case (bus_addr)
         A_WHO:   bus_rdata = {27'd0, bus_cpu};
         A_ACK:   bus_rdata = {cur_pend[1], 30'd0, cur_pend[0]};
         A_MSET:  bus_rdata = {cur_mask[1], 30'd0, cur_mask[0]};
         default: bus_rdata = 32'd0;
      endcase
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0));                                     // R1
   AST_IRQ_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[0] |-> ev_data[31:16] == 16'd4));                             // R7
endmodule

// File: tb/ipi_unit_test.sv
`timescale 1ns/1ps
module ipi_unit_test;
   localparam int N = 4;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [15:0] bus_addr = 16'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [4:0] bus_cpu = 5'd0;
   logic [31:0] bus_rdata;
   logic [N-1:0] ev_take = '0;
   logic [N*32-1:0] ev_data;
   logic [N-1:0] irq_out;

   int tests = 0, fails = 0;
   bit done = 1'b0;
   bit mp [N][2];
   bit mm [N][2];

   always #2.5 clk = ~clk;

   ipi_unit #(.NUM_CPUS(N)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_cpu(bus_cpu), .bus_rdata(bus_rdata),
      .ev_take(ev_take), .ev_data(ev_data), .irq_out(irq_out)
   );

   function automatic logic [31:0] exp_ev(int c);
      if (mp[c][0] && !mm[c][0]) return 32'h0004_0001;
      if (mp[c][1] && !mm[c][1]) return 32'h0004_0002;
      return 32'h0;
   endfunction

   task automatic chk(string req, string ctx, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
      end
   endtask

   task automatic check_all(string req, string ctx);
      for (int c = 0; c < N; c++) begin
         chk(req, ctx, ev_data[c*32 +: 32], exp_ev(c));
         chk(req, ctx, {31'd0, irq_out[c]}, {31'd0, exp_ev(c) != 0});
         bus_addr = 16'h200c; bus_cpu = 5'(c); #0.2;
         chk("R4", ctx, bus_rdata, {mp[c][1], 30'd0, mp[c][0]});
         bus_addr = 16'h2024; #0.2;
         chk("R5", ctx, bus_rdata, {mm[c][1], 30'd0, mm[c][0]});
      end
   endtask

   task automatic model_write(logic [15:0] a, logic [31:0] d, int cpu);
      for (int c = 0; c < N; c++) begin
         logic [15:0] o = 16'(c << 7);
         bit cur = (cpu == c);
         if (a == 16'h2008) begin
            if (d[c]) mp[c][0] = 1;
            if (cur && d[31]) mp[c][1] = 1;
         end
         if (a == 16'h5008 + o) begin if (d[0]) mp[c][0] = 1; if (d[31]) mp[c][1] = 1; end
         if ((a == 16'h200c && cur) || a == 16'h500c + o) begin
            if (d[0]) mp[c][0] = 0; if (d[31]) mp[c][1] = 0;
         end
         if ((a == 16'h2024 && cur) || a == 16'h5024 + o) begin
            if (d[0]) mm[c][0] = 1; if (d[31]) mm[c][1] = 1;
         end
         if ((a == 16'h2028 && cur) || a == 16'h5028 + o) begin
            if (d[0]) mm[c][0] = 0; if (d[31]) mm[c][1] = 0;
         end
      end
   endtask

   task automatic cyc(bit wr, logic [15:0] a, logic [31:0] d, int cpu, logic [N-1:0] tk,
                      string req, string ctx);
      int pk [N];
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; bus_cpu = 5'(cpu); ev_take = tk;
      for (int c = 0; c < N; c++) begin
         logic [31:0] e = exp_ev(c);
         pk[c] = (tk[c] && e != 0) ? ((e[15:0] == 16'd1) ? 0 : 1) : -1;
      end
      if (wr) model_write(a, d, cpu);
      for (int c = 0; c < N; c++) if (pk[c] >= 0) mm[c][pk[c]] = 1;
      @(negedge clk);
      bus_wr = 1'b0; ev_take = '0;
      check_all(req, ctx);
   endtask

   initial begin
      for (int c = 0; c < N; c++) begin mp[c] = '{0, 0}; mm[c] = '{1, 1}; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1", "after reset");
      for (int c = 0; c < N; c++) begin
         bus_addr = 16'h2000; bus_cpu = 5'(c); #0.2;
         chk("R2", "who-am-I", bus_rdata, 32'(c));
      end
      // R10: raise while masked, then unmask through per-CPU windows (R6)
      cyc(1, 16'h2008, 32'h8000_0005, 1, '0, "R3", "bitmap send + self");
      cyc(1, 16'h2008, 32'h7FFF_FFF0, 2, '0, "R3", "bits above NUM_CPUS");
      for (int c = 0; c < N; c++)
         cyc(1, 16'h5028 + 16'(c << 7), 32'h8000_0001, 0, '0, "R10", "unmask per-CPU");
      cyc(1, 16'h5008, 32'h8000_0000, 3, '0, "R6", "per-CPU self raise on cpu0");
      chk("R8", "both live", ev_data[15:0], 32'h1);
      cyc(0, 16'h0, 32'h0, 0, 4'b0001, "R9", "take other");
      chk("R8", "self after other masked", ev_data[31:0], 32'h0004_0002);
      cyc(1, 16'h200c, 32'h8000_0000, 0, '0, "R4", "ack self");
      cyc(1, 16'h2028, 32'h0000_0001, 0, '0, "R5", "unmask other");
      cyc(1, 16'h2028, 32'h0000_0001, 0, 4'b0001, "R11", "take vs mask clear");
      chk("R11", "mask stays", {31'd0, mm[0][0]}, 32'd1);
      cyc(1, 16'h2024, 32'h8000_0001, 2, '0, "R5", "mask cpu2");
      cyc(1, 16'h2008, 32'h0000_0004, 1, '0, "R10", "send to masked");
      cyc(1, 16'h2028, 32'h0000_0001, 2, '0, "R10", "deliver on unmask");
      chk("R10", "event after unmask", ev_data[95:64], 32'h0004_0001);
      void'($urandom(32'd1234));
      for (int i = 0; i < 600; i++) begin
         int cpu = $urandom_range(N - 1, 0);
         logic [31:0] d = $urandom;
         logic [15:0] a;
         case ($urandom_range(7, 0))
            0: a = 16'h2008; 1: a = 16'h200c; 2: a = 16'h2024; 3: a = 16'h2028;
            4: a = 16'h5008 + 16'($urandom_range(N - 1, 0) << 7);
            5: a = 16'h500c + 16'($urandom_range(N - 1, 0) << 7);
            6: a = 16'h5024 + 16'($urandom_range(N - 1, 0) << 7);
            default: a = 16'h5028 + 16'($urandom_range(N - 1, 0) << 7);
         endcase
         cyc($urandom_range(3, 0) != 0, a, d, cpu, N'($urandom), "R7", "random");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule